// File: doc/BRIEF.md
# Compare-Match Timer with Pin Actions

An 8-bit up-counter driven by a selectable clock prescaler, with two compare channels. Each channel compares the count against its own compare register. On a match it sets a sticky flag and applies an action to its output bit: toggle, clear or set. A two-bit wave field picks one of two count modes. In free-running mode the counter wraps from 0xFF to 0 and raises an overflow flag. In clear-on-match mode the counter returns to 0 on the tick after it reaches the channel A compare value.

Software reaches the block through a small synchronous register bus. Writes take effect on the clock edge, and reads are combinational from the current address. Each channel reports whether it has taken over its pin. A channel takes over its pin when its action code is nonzero. The driver enable for the pin also needs the pin's direction bit. All logic runs on the block clock; the counter moves only on prescaled ticks.

Top module: `ctc_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `cmp_out`, `cmp_ovr`, `drv_en` and `irq_flags` are 0.
- R2: Address 0 is the control register. Bits 7:6 are the channel A action, bits 5:4 are the channel B action, and bits 1:0 are the wave field. Bits 3:2 always read 0 and writes to them are ignored.
- R3: Address 1 bits 1:0 select the count rate. The codes are 0 stopped, 1 every clock, 2 every 8th clock and 3 every 64th clock. A write to this address restarts the prescaler, so with code 2 the first count lands on the 8th rising edge after the write edge. Without a tick or a write, the counter holds.
- R4: With any wave field other than 2, each tick adds one to the counter (address 2). A tick taken at 0xFF wraps the counter to 0 and sets flag bit 2.
- R5: With wave field 2, a tick taken while the counter equals compare register A (address 3) loads 0 instead of incrementing. The observed sequence is TOP-1, TOP, 0, 1.
- R6: A tick taken while the counter equals compare register A (address 3) or B (address 4) sets flag bit 0 or bit 1. The flags read at address 5 and drive `irq_flags`. A flag stays set until a 1 is written to its bit at address 5. A set and a clear in the same cycle leave the flag set.
- R7: On a channel's match tick, action code 1 toggles its `cmp_out` bit, code 2 clears it and code 3 sets it. Code 0 leaves it unchanged.
- R8: `cmp_ovr[x]` is 1 exactly when channel x's action code is nonzero. `drv_en[x]` is 1 exactly when `cmp_ovr[x]` and `pin_dir[x]` are both 1.
- R9: A write to address 2 loads the counter and overrides a tick in the same cycle. The next tick after such a write raises no compare match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_dir | input | 2 | Direction bit of each channel's pin (bit 0 = A) |
| cmp_out | output | 2 | Compare output value per channel |
| cmp_ovr | output | 2 | Channel has taken over its pin |
| drv_en | output | 2 | Pin driver enable per channel |
| irq_flags | output | 3 | Match B, match A and overflow flags (bit 1, bit 0, bit 2) |

## Verification
The hardest case to reach is a counter write colliding with a compare value. The bench must write exactly the compare value and then let the following tick pass without a flag. Directed steps load the counter with the compare value at single-clock rate and check that no flag appears. Further directed steps cover the clear-on-match wrap at a small TOP and the eight-clock prescaler delay. Seeded random bus traffic then mixes counter writes, mode changes and flag clears against a cycle model.

// File: rtl/ctc_timer.sv
module ctc_timer #(
  parameter int W      = 8,
  parameter int AW     = 3,
  parameter int MID_LG = 3,
  parameter int PRE_W  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  input  logic [1:0]    pin_dir,
  output logic [1:0]    cmp_out,
  output logic [1:0]    cmp_ovr,
  output logic [1:0]    drv_en,
  output logic [2:0]    irq_flags
);
  localparam logic [W-1:0] TOP_MAX = '1;

  logic [7:0]       ctrl;
  logic [1:0]       sel;
  logic [PRE_W-1:0] pre;
  logic [W-1:0]     cnt, cmpa, cmpb;
  logic [2:0]       flg;
  logic [1:0]       oc;
  logic             blk;

  function automatic logic act(input logic [1:0] m, input logic cur);
    case (m)
      2'b01:   act = ~cur;
      2'b10:   act = 1'b0;
      2'b11:   act = 1'b1;
      default: act = cur;
    endcase
  endfunction

  wire wr_at0 = bus_we && bus_addr == AW'(0);
  wire wr_at1 = bus_we && bus_addr == AW'(1);
  wire cnt_wr = bus_we && bus_addr == AW'(2);
  wire wr_at3 = bus_we && bus_addr == AW'(3);
  wire wr_at4 = bus_we && bus_addr == AW'(4);
  wire wr_at5 = bus_we && bus_addr == AW'(5);

  wire ctc  = ctrl[1:0] == 2'b10;
  wire tick = (sel == 2'd1) ||
              (sel == 2'd2 && &pre[MID_LG-1:0]) ||
              (sel == 2'd3 && &pre);
  wire adv   = tick && !cnt_wr;
  wire hit_a = adv && !blk && cnt == cmpa;
  wire hit_b = adv && !blk && cnt == cmpb;
  wire wrap  = adv && cnt == TOP_MAX;
  wire [2:0] flg_set = {wrap, hit_b, hit_a};
  wire [2:0] flg_clr = wr_at5 ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; sel <= '0; pre <= '0; cnt <= '0;
      cmpa <= '0; cmpb <= '0; flg <= '0; oc <= '0; blk <= 1'b0;
    end else begin
      if (wr_at0) ctrl <= bus_wdata[7:0] & 8'hF3;
      if (wr_at1) begin
        sel <= bus_wdata[1:0];
        pre <= '0;
      end else begin
        pre <= pre + 1'b1;
      end
      if (cnt_wr)                 cnt <= bus_wdata;
      else if (tick && ctc && cnt == cmpa) cnt <= '0;
      else if (tick)              cnt <= cnt + 1'b1;
      if (cnt_wr)    blk <= 1'b1;
      else if (tick) blk <= 1'b0;
      if (wr_at3) cmpa <= bus_wdata;
      if (wr_at4) cmpb <= bus_wdata;
      flg <= (flg & ~flg_clr) | flg_set;
      if (hit_a) oc[0] <= act(ctrl[7:6], oc[0]);
      if (hit_b) oc[1] <= act(ctrl[5:4], oc[1]);
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = W'(ctrl);
      AW'(1):  bus_rdata = W'(sel);
      AW'(2):  bus_rdata = cnt;
      AW'(3):  bus_rdata = cmpa;
      AW'(4):  bus_rdata = cmpb;
      AW'(5):  bus_rdata = W'(flg);
      default: bus_rdata = '0;
    endcase
  end

  assign cmp_out   = oc;
  assign cmp_ovr   = {ctrl[5:4] != 2'b00, ctrl[7:6] != 2'b00};
  assign drv_en    = cmp_ovr & pin_dir;
  assign irq_flags = flg;
endmodule

module ctc_timer_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_wr,
  input logic          ctc,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  cmpa,
  input logic [2:0]    flg,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == AW'(0) |-> bus_rdata[3:2] == 2'b00);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(cnt));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && !ctc |=> cnt == W'($past(cnt) + 1'b1));
  p_ctc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && ctc && cnt == cmpa |=> cnt == '0);
  p_flag_a_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flg[0] && !(bus_we && bus_addr == AW'(5) && bus_wdata[0]) |=> flg[0]);
  p_flag_b_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flg[1] && !(bus_we && bus_addr == AW'(5) && bus_wdata[1]) |=> flg[1]);
  p_cnt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(bus_wdata));
endmodule

bind ctc_timer ctc_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .ctc(ctc),
  .cnt(cnt), .cmpa(cmpa), .flg(flg), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/ctc_timer_tb.sv
module ctc_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [1:0] pin_dir = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cmp_out, cmp_ovr, drv_en;
  logic [2:0] irq_flags;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  ctc_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_dir(pin_dir), .cmp_out(cmp_out),
    .cmp_ovr(cmp_ovr), .drv_en(drv_en), .irq_flags(irq_flags));

  logic [7:0] m_ctrl, m_cnt, m_cmpa, m_cmpb;
  logic [1:0] m_sel, m_oc;
  logic [5:0] m_pre;
  logic [2:0] m_flg;
  logic       m_blk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic do_act(input logic [1:0] m, input logic cur);
    return m == 2'd1 ? ~cur : m == 2'd2 ? 1'b0 : m == 2'd3 ? 1'b1 : cur;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return {6'd0, m_sel};
      3'd2: return m_cnt;
      3'd3: return m_cmpa;
      3'd4: return m_cmpb;
      3'd5: return {5'd0, m_flg};
      default: return 8'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_ctrl = 0; m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_sel = 0;
    m_oc = 0; m_pre = 0; m_flg = 0; m_blk = 0;
  endtask

  task automatic m_update();
    logic tk, cw, ha, hb, wr;
    logic [2:0] clr;
    tk = (m_sel == 1) || (m_sel == 2 && m_pre[2:0] == 3'd7) || (m_sel == 3 && m_pre == 6'd63);
    cw = bus_we && bus_addr == 3'd2;
    ha = tk && !cw && !m_blk && m_cnt == m_cmpa;
    hb = tk && !cw && !m_blk && m_cnt == m_cmpb;
    wr = tk && !cw && m_cnt == 8'hFF;
    clr = (bus_we && bus_addr == 3'd5) ? bus_wdata[2:0] : 3'd0;
    m_flg = (m_flg & ~clr) | {wr, hb, ha};
    if (ha) m_oc[0] = do_act(m_ctrl[7:6], m_oc[0]);
    if (hb) m_oc[1] = do_act(m_ctrl[5:4], m_oc[1]);
    if (cw) m_cnt = bus_wdata;
    else if (tk) m_cnt = (m_ctrl[1:0] == 2'b10 && m_cnt == m_cmpa) ? 8'd0 : m_cnt + 8'd1;
    if (cw) m_blk = 1; else if (tk) m_blk = 0;
    if (bus_we && bus_addr == 3'd1) begin m_sel = bus_wdata[1:0]; m_pre = 0; end
    else m_pre = m_pre + 6'd1;
    if (bus_we && bus_addr == 3'd0) m_ctrl = bus_wdata & 8'hF3;
    if (bus_we && bus_addr == 3'd3) m_cmpa = bus_wdata;
    if (bus_we && bus_addr == 3'd4) m_cmpb = bus_wdata;
  endtask

  task automatic step();
    logic [1:0] ov;
    string tag;
    @(posedge clk);
    m_update();
    @(negedge clk);
    ov = {m_ctrl[5:4] != 0, m_ctrl[7:6] != 0};
    case (bus_addr)
      3'd0: tag = "R2 ctrl read";
      3'd1: tag = "R3 rate read";
      3'd2: tag = "R4 count read";
      3'd5: tag = "R6 flag read";
      default: tag = "R5 compare read";
    endcase
    chk(tag, bus_rdata, m_read(bus_addr));
    chk("R6 irq_flags", irq_flags, m_flg);
    chk("R7 cmp_out", cmp_out, m_oc);
    chk("R8 cmp_ovr", cmp_ovr, ov);
    chk("R8 drv_en", drv_en, ov & pin_dir);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; step(); bus_we = 0;
  endtask

  task automatic peek(input logic [2:0] a, input string tag, input int exp);
    bus_addr = a; #0.1; chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) peek(3'(a), "R1 reset reg", 0);
    chk("R1 outputs", {cmp_out, cmp_ovr, drv_en, irq_flags}, 0);
    // R2 reserved bits dropped
    wr(3'd0, 8'hFF);
    peek(3'd0, "R2 reserved", 8'hF3);
    wr(3'd0, 8'h00);
    // R9 write of compare value suppresses match
    wr(3'd3, 8'd5);
    wr(3'd1, 8'd1);
    wr(3'd2, 8'd5);
    bus_addr = 3'd2; step();
    chk("R9 no match after write", irq_flags[0], 0);
    peek(3'd2, "R9 counted on", 6);
    // R5 clear-on-match sequence with TOP=3, R7 set action
    wr(3'd0, 8'hC2);
    wr(3'd3, 8'd3);
    wr(3'd2, 8'd2);
    bus_addr = 3'd2;
    step(); peek(3'd2, "R5 TOP", 3);
    step(); peek(3'd2, "R5 BOTTOM", 0);
    chk("R6 flag A on wrap", irq_flags[0], 1);
    chk("R7 set action", cmp_out[0], 1);
    step(); peek(3'd2, "R5 BOTTOM+1", 1);
    wr(3'd5, 8'h07);
    chk("R6 cleared", irq_flags[1:0], 0);
    // R3 eighth-clock rate
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd2);
    wr(3'd2, 8'd40);
    bus_addr = 3'd2;
    repeat (6) step();
    peek(3'd2, "R3 before 8th edge", 40);
    step();
    peek(3'd2, "R3 at 8th edge", 41);
    // R4 overflow
    wr(3'd1, 8'd1);
    wr(3'd2, 8'hFE);
    bus_addr = 3'd2;
    step(); step();
    peek(3'd2, "R4 wrap", 0);
    chk("R4 overflow flag", irq_flags[2], 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom % 7);
      d = 8'($urandom);
      if (a == 3'd1 && ($urandom % 8) != 0) d = 8'd1;
      if (a == 3'd3 || a == 3'd4) d = d & 8'h1F;
      if (($urandom % 16) == 0) pin_dir = 2'($urandom);
      bus_addr = a; bus_wdata = d; bus_we = ($urandom % 4) == 0;
      step();
      bus_we = 0;
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule